// File: doc/BRIEF.md
# Masked Control Register File

This block holds the control and status registers of a small processor core: 32 slots of 32 bits, selected by a 5-bit index. The core issues a read through one index and a write through another, and both can happen in the same cycle. Each slot is configured at elaboration time in one of three ways:

- **Reserved:** both masks are zero.
- **Read-only:** the writable mask is zero and the read-only mask is nonzero.
- **Writable:** the writable mask is nonzero. Such a slot may be fully or only partly writable.

A write stores the new data through the writable mask and keeps the old contents through the read-only mask. Any bit that lies in neither mask clears to zero.

The pending-interrupt slot has no storage. A read of it returns the raw interrupt lines ANDed with the interrupt-enable register. Every access made while the core is in user mode is refused. A refused access raises a privilege-fault flag and changes nothing. An accepted write to the status or interrupt-enable slot raises a re-evaluate strobe, so that the interrupt logic can take an interrupt that the write has just unmasked.

Top module: `ctlRegFile`

## Requirements
- R1: The slots sit at fixed index values: status 0, saved exception status 1, saved breakpoint status 2, interrupt enable 3, interrupt pending 4, CPU id 5, exception cause 7 and bad address 12. A value written to a writable slot reads back unchanged in the bits its mask allows.
- R2: After reset every slot reads zero, except CPU id, which reads the parameter `CPU_ID` (default 32'h0000_1A2B).
- R3: While `userMode` is 1, any read or write asserts `privFault` in the same cycle. In that cycle `rdData` is 0 and `reevalStrobe` is 0, and no slot changes.
- R4: Reserved slots are 6, 8 to 11 and 13 to 31. They read zero, and writes to them have no effect.
- R5: A write to a slot whose writable mask is zero is ignored. With the default masks these slots are CPU id and pending.
- R6: A write stores (new & writable) | (old & read-only). The default writable masks are 32'h3 for the three status slots, 32'h7C for exception cause, and all ones for interrupt enable and bad address.
- R7: A read of the pending slot returns `irqLines` & interrupt enable. That value is never stored.
- R8: `reevalStrobe` is 1 in exactly the cycles that carry an accepted write to slot 0 or slot 3.
- R9: Reads are combinational. A write takes effect at the clock edge, so a read of the same slot in the write's cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| userMode | input | 1 | 1 when the core runs unprivileged |
| rdEn | input | 1 | Read request |
| rdIdx | input | 5 | Read slot index |
| rdData | output | 32 | Read result; 0 when no read is accepted |
| wrEn | input | 1 | Write request |
| wrIdx | input | 5 | Write slot index |
| wrData | input | 32 | Write data |
| irqLines | input | 32 | Raw interrupt request lines |
| privFault | output | 1 | Access refused because of user mode |
| reevalStrobe | output | 1 | An accepted write to status or interrupt enable |

## Verification
The assertions take for granted that the indices and the data are driven to known values whenever the matching enable is high. They also take for granted that `userMode` is stable for the whole cycle in which it is sampled. The stimulus changes all inputs only on the falling clock edge and always drives every field, including fields of ports that are disabled. The interrupt lines are given fresh patterns only in cycles that read the pending slot, so that the pending value can be checked against the lines that produced it.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int IDXW = $clog2(NREG);

  localparam int IDX_STATUS = 0;
  localparam int IDX_ESTAT  = 1;
  localparam int IDX_BSTAT  = 2;
  localparam int IDX_IEN    = 3;
  localparam int IDX_PEND   = 4;
  localparam int IDX_CPUID  = 5;
  localparam int IDX_CAUSE  = 7;
  localparam int IDX_BADADR = 12;

  typedef logic [NREG-1:0][DW-1:0] maskSet_t;

  typedef struct packed {
    logic            rdAccept;
    logic [IDXW-1:0] rdIdx;
    logic            wrAccept;
    logic [IDXW-1:0] wrIdx;
    logic            reeval;
  } ctlStrobes_t;

  function automatic maskSet_t defWrMask();
    maskSet_t m = '0;
    m[IDX_STATUS] = 32'h0000_0003;
    m[IDX_ESTAT]  = 32'h0000_0003;
    m[IDX_BSTAT]  = 32'h0000_0003;
    m[IDX_IEN]    = '1;
    m[IDX_CAUSE]  = 32'h0000_007C;
    m[IDX_BADADR] = '1;
    return m;
  endfunction

  function automatic maskSet_t defRoMask();
    maskSet_t m = '0;
    m[IDX_PEND]  = '1;
    m[IDX_CPUID] = '1;
    return m;
  endfunction
endpackage

// File: rtl/ctlreg_ctrl.sv
module ctlreg_ctrl
  import ctlreg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             userMode,
  input  logic             rdEn,
  input  logic [IDXW-1:0]  rdIdx,
  input  logic             wrEn,
  input  logic [IDXW-1:0]  wrIdx,
  output ctlStrobes_t      strobes,
  output logic             privFault
);
  logic supervisor;
  logic hitsIrqCtl;

  assign supervisor = !userMode;
  assign hitsIrqCtl = (wrIdx == IDXW'(IDX_STATUS)) || (wrIdx == IDXW'(IDX_IEN));

  always_comb begin
    strobes.rdAccept = rdEn && supervisor;
    strobes.rdIdx    = rdIdx;
    strobes.wrAccept = wrEn && supervisor;
    strobes.wrIdx    = wrIdx;
    strobes.reeval   = wrEn && supervisor && hitsIrqCtl;
  end

  assign privFault = userMode && (rdEn || wrEn);

  // R3: a faulting cycle carries no accepted access
  p_fault_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> (!strobes.wrAccept && !strobes.rdAccept && !strobes.reeval));

  // R8: re-evaluate only accompanies an accepted write
  p_reeval_needs_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reeval |-> (strobes.wrAccept && wrEn && !userMode));
endmodule

// File: rtl/ctlreg_dp.sv
module ctlreg_dp
  import ctlreg_pkg::*;
#(
  parameter maskSet_t      WR_MASK = defWrMask(),
  parameter maskSet_t      RO_MASK = defRoMask(),
  parameter logic [DW-1:0] CPU_ID  = 32'h0000_1A2B
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     strobes,
  input  logic [DW-1:0]   wrData,
  input  logic [DW-1:0]   irqLines,
  output logic [DW-1:0]   rdData
);
  logic [DW-1:0] regQ [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam logic [DW-1:0] WRM = WR_MASK[i];
    localparam logic [DW-1:0] ROM = RO_MASK[i];
    localparam bit STORED   = ((WRM != '0) || (ROM != '0)) && (i != IDX_PEND);
    localparam bit CANWRITE = (WRM != '0);
    localparam logic [DW-1:0] RSTV = (i == IDX_CPUID) ? CPU_ID : '0;

    if (STORED) begin : g_flop
      logic hit;
      assign hit = strobes.wrAccept && (strobes.wrIdx == IDXW'(i)) && CANWRITE;

      always_ff @(posedge clk) begin
        if (!rstN)    regQ[i] <= RSTV;
        else if (hit) regQ[i] <= (wrData & WRM) | (regQ[i] & ROM);
      end

      // R5: a slot that is not the target of an accepted write holds its value
      p_hold_untargeted_r5: assert property (@(posedge clk) disable iff (!rstN)
        !(strobes.wrAccept && (strobes.wrIdx == IDXW'(i))) |=> $stable(regQ[i]));

      if (CANWRITE) begin : g_chk
        // R6: the stored value follows the mask merge
        p_masked_store_r6: assert property (@(posedge clk) disable iff (!rstN)
          (strobes.wrAccept && (strobes.wrIdx == IDXW'(i))) |=>
            (((regQ[i] & WRM) == ($past(wrData) & WRM)) &&
             ((regQ[i] & ~(WRM | ROM)) == '0)));
      end
    end else begin : g_none
      assign regQ[i] = '0;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdAccept) begin
      if (strobes.rdIdx == IDXW'(IDX_PEND)) rdData = irqLines & regQ[IDX_IEN];
      else                                  rdData = regQ[strobes.rdIdx];
    end
  end

  // R7: the pending view never shows a line that is not raised
  p_pending_subset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdAccept && (strobes.rdIdx == IDXW'(IDX_PEND))) |->
      ((rdData & ~irqLines) == '0));
endmodule

// File: rtl/ctlRegFile.sv
module ctlRegFile
  import ctlreg_pkg::*;
#(
  parameter maskSet_t      WR_MASK = defWrMask(),
  parameter maskSet_t      RO_MASK = defRoMask(),
  parameter logic [DW-1:0] CPU_ID  = 32'h0000_1A2B
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            userMode,
  input  logic            rdEn,
  input  logic [IDXW-1:0] rdIdx,
  output logic [DW-1:0]   rdData,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [DW-1:0]   wrData,
  input  logic [DW-1:0]   irqLines,
  output logic            privFault,
  output logic            reevalStrobe
);
  ctlStrobes_t strobes;

  ctlreg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .userMode(userMode),
    .rdEn(rdEn), .rdIdx(rdIdx), .wrEn(wrEn), .wrIdx(wrIdx),
    .strobes(strobes), .privFault(privFault)
  );

  ctlreg_dp #(.WR_MASK(WR_MASK), .RO_MASK(RO_MASK), .CPU_ID(CPU_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrData(wrData), .irqLines(irqLines), .rdData(rdData)
  );

  assign reevalStrobe = strobes.reeval;

  // R3: user mode never exposes register contents
  p_user_read_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    userMode |-> (rdData == '0 && !reevalStrobe));

  // R4: slots with no masks read zero
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !userMode && rdIdx != IDXW'(IDX_PEND) &&
     WR_MASK[rdIdx] == '0 && RO_MASK[rdIdx] == '0) |-> (rdData == '0));
endmodule

// File: tb/ctlRegFile_test.sv
module ctlRegFile_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        userMode, rdEn, wrEn;
  logic [4:0]  rdIdx, wrIdx;
  logic [31:0] wrData, irqLines, rdData;
  logic        privFault, reevalStrobe;

  int applied = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  ctlRegFile uut (
    .clk(clk), .rstN(rstN), .userMode(userMode),
    .rdEn(rdEn), .rdIdx(rdIdx), .rdData(rdData),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .irqLines(irqLines), .privFault(privFault), .reevalStrobe(reevalStrobe)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        user;
    logic        we;
    logic [4:0]  wi;
    logic [31:0] wd;
    logic        re;
    logic [4:0]  ri;
    logic [31:0] irq;
    logic [31:0] expRd;
    logic        expFault;
    logic        expReeval;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd0,  32'h0,         32'h0,         1'b0, 1'b0}, // R2 status
    '{4'd2, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd5,  32'h0,         32'h0000_1A2B, 1'b0, 1'b0}, // R2 cpu id
    '{4'd9, 1'b0, 1'b1, 5'd0,  32'hFFFF_FFFF, 1'b1, 5'd0,  32'h0,         32'h0,         1'b0, 1'b1}, // R9 old value, R8
    '{4'd6, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd0,  32'h0,         32'h0000_0003, 1'b0, 1'b0}, // R6 status
    '{4'd8, 1'b0, 1'b1, 5'd3,  32'h0000_00F0, 1'b1, 5'd3,  32'h0,         32'h0,         1'b0, 1'b1}, // R8 ienable
    '{4'd7, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd4,  32'h0000_0FFF, 32'h0000_00F0, 1'b0, 1'b0}, // R7
    '{4'd7, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd4,  32'h0000_0030, 32'h0000_0030, 1'b0, 1'b0}, // R7
    '{4'd5, 1'b0, 1'b1, 5'd4,  32'hFFFF_FFFF, 1'b1, 5'd3,  32'h0,         32'h0000_00F0, 1'b0, 1'b0}, // R5 pending write
    '{4'd5, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd4,  32'hFFFF_FFFF, 32'h0000_00F0, 1'b0, 1'b0}, // R5
    '{4'd5, 1'b0, 1'b1, 5'd5,  32'h0,         1'b1, 5'd12, 32'h0,         32'h0,         1'b0, 1'b0}, // R5 cpu id write
    '{4'd5, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd5,  32'h0,         32'h0000_1A2B, 1'b0, 1'b0}, // R5
    '{4'd6, 1'b0, 1'b1, 5'd7,  32'hFFFF_FFFF, 1'b1, 5'd7,  32'h0,         32'h0,         1'b0, 1'b0}, // R6 cause
    '{4'd6, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd7,  32'h0,         32'h0000_007C, 1'b0, 1'b0}, // R6
    '{4'd4, 1'b0, 1'b1, 5'd6,  32'hFFFF_FFFF, 1'b1, 5'd6,  32'h0,         32'h0,         1'b0, 1'b0}, // R4
    '{4'd4, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd6,  32'h0,         32'h0,         1'b0, 1'b0}, // R4
    '{4'd4, 1'b0, 1'b1, 5'd12, 32'hDEAD_BEEF, 1'b1, 5'd31, 32'h0,         32'h0,         1'b0, 1'b0}, // R4
    '{4'd1, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd12, 32'h0,         32'hDEAD_BEEF, 1'b0, 1'b0}, // R1
    '{4'd3, 1'b1, 1'b1, 5'd12, 32'h0,         1'b1, 5'd12, 32'h0,         32'h0,         1'b1, 1'b0}, // R3
    '{4'd3, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd12, 32'h0,         32'hDEAD_BEEF, 1'b0, 1'b0}, // R3
    '{4'd3, 1'b1, 1'b1, 5'd0,  32'h0,         1'b0, 5'd0,  32'h0,         32'h0,         1'b1, 1'b0}, // R3
    '{4'd3, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd0,  32'h0,         32'h0000_0003, 1'b0, 1'b0}, // R3
    '{4'd6, 1'b0, 1'b1, 5'd1,  32'h0000_0005, 1'b1, 5'd1,  32'h0,         32'h0,         1'b0, 1'b0}, // R6
    '{4'd6, 1'b0, 1'b1, 5'd2,  32'hFFFF_FFFE, 1'b1, 5'd1,  32'h0,         32'h0000_0001, 1'b0, 1'b0}, // R6
    '{4'd6, 1'b0, 1'b0, 5'd0,  32'h0,         1'b1, 5'd2,  32'h0,         32'h0000_0002, 1'b0, 1'b0}  // R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    userMode = 1'b0; rdEn = 1'b0; wrEn = 1'b0;
    rdIdx = '0; wrIdx = '0; wrData = '0; irqLines = '0;
  endtask

  task automatic applyVec(input vec_t v);
    @(negedge clk);
    userMode = v.user; wrEn = v.we; wrIdx = v.wi; wrData = v.wd;
    rdEn = v.re; rdIdx = v.ri; irqLines = v.irq;
    #2;
    check($sformatf("R%0d rdData", v.req), rdData, v.expRd);
    check($sformatf("R%0d privFault", v.req), {31'b0, privFault}, {31'b0, v.expFault});
    check($sformatf("R%0d reevalStrobe", v.req), {31'b0, reevalStrobe}, {31'b0, v.expReeval});
  endtask

  task automatic doReset();
    @(negedge clk); idle(); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0;
    idle();
    doReset();
    for (int k = 0; k < NV; k++) applyVec(VEC[k]);

    // R2: a second reset clears writable slots and restores CPU id
    doReset();
    applyVec('{4'd2, 1'b0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd12, 32'h0, 32'h0, 1'b0, 1'b0});
    applyVec('{4'd2, 1'b0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd3,  32'h0, 32'h0, 1'b0, 1'b0});
    applyVec('{4'd2, 1'b0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd5,  32'h0, 32'h0000_1A2B, 1'b0, 1'b0});
    // R7: pending with enable zero reads zero whatever the lines are
    applyVec('{4'd7, 1'b0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0});
    // R3: user-mode read alone faults and hides data
    applyVec('{4'd3, 1'b1, 1'b0, 5'd0, 32'h0, 1'b1, 5'd5, 32'h0, 32'h0, 1'b1, 1'b0});
    // R8: write to bad address does not re-evaluate; idle has no fault
    applyVec('{4'd8, 1'b0, 1'b1, 5'd12, 32'h1234_5678, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0});
    applyVec('{4'd1, 1'b0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd12, 32'h0, 32'h1234_5678, 1'b0, 1'b0});
    // R4: every reserved slot stays zero after writes of all ones
    for (int s = 13; s < 32; s++)
      applyVec('{4'd4, 1'b0, 1'b1, 5'(s), 32'hFFFF_FFFF, 1'b1, 5'(s), 32'h0, 32'h0, 1'b0, 1'b0});
    for (int s = 8; s < 12; s++) begin
      applyVec('{4'd4, 1'b0, 1'b1, 5'(s), 32'hFFFF_FFFF, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0});
      applyVec('{4'd4, 1'b0, 1'b0, 5'd0, 32'h0, 1'b1, 5'(s), 32'h0, 32'h0, 1'b0, 1'b0});
    end

    @(negedge clk); idle();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule